// File: doc/BRIEF.md
# Special-Purpose Register Access Unit

This block serves the move-to and move-from special-purpose-register operations of a 32-bit processor pipeline. It takes the instruction word, extracts the 10-bit register number from it, and either reads or writes one register of a small local bank. The bank holds the following registers:

- the exception register, with its carry flag kept in a separate flop;
- fault status and fault address;
- the decrementer and the page-table base;
- two save/restore registers and a group of scratch registers;
- a read-only version register;
- two implementation-control registers and a process identifier.

The two 5-bit register-number fields sit in the instruction word in swapped order, and the block reassembles them. Register numbers whose upper half is 0x10 or 0x11 do not touch the local bank. They are handed out on a redirect port to an external address-translation register array. The data that array returns is passed straight back as read data.

Read data is combinational from the decoded number while a read is presented. A write takes effect on the next rising clock edge. Two writes have side effects, each seen as a one-cycle pulse in the cycle after the write edge:

- a decrementer write raises the timer-arm pulse;
- a page-table-base write raises the translation-invalidate pulse.

The decrementer and time-base counters themselves live elsewhere. This block only provides the decrementer's load path and a read view of a 64-bit time-base input.

Top module: `spr_access_unit`

## Requirements
- R1: The register number is {instr[15:11], instr[20:16]}, with instr[15:11] as the upper five bits. A write to a number followed by a read of the same number returns the written data.
- R2: When the upper five bits of the number are 0x10 or 0x11 and an access is presented, the access is redirected:
  - xlat_sel is high and xlat_index carries the low six bits of the number;
  - xlat_write equals acc_write and xlat_wdata equals wr_data;
  - a read returns xlat_rdata;
  - no local register changes.
  For every other access, xlat_sel and xlat_write stay low.
- R3: The exception register (number 1) stores bit 29 of the write data as a separate carry flag and the other bits as its body. A read merges the carry back at bit 29, so it returns exactly the last written word.
- R4: A write to the decrementer (number 22) loads the data. timer_arm is high for exactly the one cycle after each such write edge, and at no other time.
- R5: A write to the page-table base (number 25) stores the data. xlat_inval is high for exactly the one cycle after each such write edge, and at no other time.
- R6: Reading a number that is not implemented returns zero. Writing one changes no register.
- R7: Number 268 reads time_base[31:0] and number 269 reads time_base[63:32]. Writes to either number have no effect.
- R8: The version register (number 287) reads the VERSION parameter after reset. Writes to it have no effect.
- R9: After reset, every writable register reads zero and neither pulse output is high.
- R10: The following numbers are read/write and hold the last value written:
  - status 18, address 19, decrementer 22, page-table base 25;
  - save/restore 26 and 27;
  - scratch 272 to 272+SCRATCH_N-1;
  - implementation 1008 and 1009, process ID 945.
- R11: rd_data is zero whenever acc_en is low or acc_write is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr | input | 32 | Instruction word carrying the register number |
| acc_en | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = move-to (write), 0 = move-from (read) |
| wr_data | input | DATA_W | Write data |
| time_base | input | 2*DATA_W | Current 64-bit time-base value |
| xlat_rdata | input | DATA_W | Read data from the external translation array |
| rd_data | output | DATA_W | Read data, combinational |
| xlat_sel | output | 1 | Access redirected to the translation array |
| xlat_write | output | 1 | Redirected access is a write |
| xlat_index | output | 6 | Entry index within the translation array |
| xlat_wdata | output | DATA_W | Write data toward the translation array |
| timer_arm | output | 1 | One-cycle pulse after a decrementer write |
| xlat_inval | output | 1 | One-cycle pulse after a page-table-base write |

## Verification
The bench builds the block with DATA_W = 32, SCRATCH_N = 4 and VERSION overridden to 0x7A5C0103. This non-zero, asymmetric pattern makes a wrong reset load or a stray write to the version register visible.

With four scratch registers, the numbers just past the scratch range (276, 277) are unimplemented. This lets the bench check the upper bound of the scratch decode.

Random writes also land on numbers whose upper half is 0x10 or 0x11, as well as on 0x0F and 0x12 just outside that range. This checks the edges of the redirect decode with the same stimulus that exercises the local bank.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Which storage element a decoded register number selects
  typedef enum logic [3:0] {
    K_NONE, K_XER, K_DSISR, K_DAR, K_DEC, K_SDR1, K_SRR0, K_SRR1,
    K_TBL, K_TBU, K_SCR, K_VER, K_IMP0, K_IMP1, K_PID, K_XLAT
  } spr_kind_e;

  localparam int SCR_W = 3;  // scratch index width (up to 8 scratch regs)

  typedef struct packed {
    spr_kind_e          kind;
    logic [SCR_W-1:0]   scr_idx;
  } spr_sel_t;

  // Architected register numbers
  localparam logic [9:0] N_XER      = 10'd1;
  localparam logic [9:0] N_DSISR    = 10'd18;
  localparam logic [9:0] N_DAR      = 10'd19;
  localparam logic [9:0] N_DEC      = 10'd22;
  localparam logic [9:0] N_SDR1     = 10'd25;
  localparam logic [9:0] N_SRR0     = 10'd26;
  localparam logic [9:0] N_SRR1     = 10'd27;
  localparam logic [9:0] N_TBL      = 10'd268;
  localparam logic [9:0] N_TBU      = 10'd269;
  localparam logic [9:0] N_SCR_BASE = 10'd272;
  localparam logic [9:0] N_VER      = 10'd287;
  localparam logic [9:0] N_PID      = 10'd945;
  localparam logic [9:0] N_IMP0     = 10'd1008;
  localparam logic [9:0] N_IMP1     = 10'd1009;

  // Upper-half codes that redirect to the translation array
  localparam logic [4:0] XLAT_HI_A  = 5'h10;
  localparam logic [4:0] XLAT_HI_B  = 5'h11;

  // The two 5-bit halves appear swapped in the instruction word
  function automatic logic [9:0] spr_number(input logic [31:0] insn);
    return {insn[15:11], insn[20:16]};
  endfunction

endpackage

// File: rtl/spr_num_decode.sv
module spr_num_decode
  import spr_pkg::*;
#(
  parameter int SCRATCH_N = 4
) (
  input  logic [9:0]  num,
  output spr_sel_t    sel,
  output logic [5:0]  xlat_idx
);

  localparam logic [9-SCR_W:0] SCR_TAG = N_SCR_BASE[9:SCR_W];

  logic scr_hit;
  logic xlat_hit;

  assign xlat_hit = (num[9:5] == XLAT_HI_A) || (num[9:5] == XLAT_HI_B);
  assign scr_hit  = (num[9:SCR_W] == SCR_TAG) &&
                    ({1'b0, num[SCR_W-1:0]} < (SCR_W+1)'(SCRATCH_N));
  assign xlat_idx = num[5:0];

  always_comb begin
    sel.kind    = K_NONE;
    sel.scr_idx = num[SCR_W-1:0];
    if (xlat_hit) begin
      sel.kind = K_XLAT;
    end else if (scr_hit) begin
      sel.kind = K_SCR;
    end else begin
      case (num)
        N_XER:   sel.kind = K_XER;
        N_DSISR: sel.kind = K_DSISR;
        N_DAR:   sel.kind = K_DAR;
        N_DEC:   sel.kind = K_DEC;
        N_SDR1:  sel.kind = K_SDR1;
        N_SRR0:  sel.kind = K_SRR0;
        N_SRR1:  sel.kind = K_SRR1;
        N_TBL:   sel.kind = K_TBL;
        N_TBU:   sel.kind = K_TBU;
        N_VER:   sel.kind = K_VER;
        N_PID:   sel.kind = K_PID;
        N_IMP0:  sel.kind = K_IMP0;
        N_IMP1:  sel.kind = K_IMP1;
        default: sel.kind = K_NONE;
      endcase
    end
  end

endmodule

// File: rtl/spr_reg_bank.sv
module spr_reg_bank
  import spr_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                CARRY_BIT = 29,
  parameter int                SCRATCH_N = 4,
  parameter logic [DATA_W-1:0] VERSION   = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  spr_sel_t             sel,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [2*DATA_W-1:0]  time_base,
  output logic [DATA_W-1:0]    rd_val,
  output logic                 arm_pulse,
  output logic                 inval_pulse
);

  localparam logic [DATA_W-1:0] CARRY_MASK = DATA_W'(1) << CARRY_BIT;

  logic [DATA_W-1:0] xer_body_q;
  logic              xer_carry_q;
  logic [DATA_W-1:0] dsisr_q, dar_q, dec_q, sdr1_q;
  logic [DATA_W-1:0] srr0_q, srr1_q;
  logic [DATA_W-1:0] imp0_q, imp1_q, pid_q, ver_q;
  logic [DATA_W-1:0] scr_q [SCRATCH_N];
  logic [DATA_W-1:0] scr_rd;

  // Single-instance registers and side-effect pulses
  always_ff @(posedge clk) begin
    if (rst) begin
      xer_body_q  <= '0;
      xer_carry_q <= 1'b0;
      dsisr_q     <= '0;
      dar_q       <= '0;
      dec_q       <= '0;
      sdr1_q      <= '0;
      srr0_q      <= '0;
      srr1_q      <= '0;
      imp0_q      <= '0;
      imp1_q      <= '0;
      pid_q       <= '0;
      arm_pulse   <= 1'b0;
      inval_pulse <= 1'b0;
    end else begin
      arm_pulse   <= 1'b0;
      inval_pulse <= 1'b0;
      if (wr_en) begin
        case (sel.kind)
          K_XER: begin
            xer_body_q  <= wr_data & ~CARRY_MASK;
            xer_carry_q <= wr_data[CARRY_BIT];
          end
          K_DSISR: dsisr_q <= wr_data;
          K_DAR:   dar_q   <= wr_data;
          K_DEC: begin
            dec_q     <= wr_data;
            arm_pulse <= 1'b1;
          end
          K_SDR1: begin
            sdr1_q      <= wr_data;
            inval_pulse <= 1'b1;
          end
          K_SRR0:  srr0_q <= wr_data;
          K_SRR1:  srr1_q <= wr_data;
          K_IMP0:  imp0_q <= wr_data;
          K_IMP1:  imp1_q <= wr_data;
          K_PID:   pid_q  <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // Version register: loaded at reset, never written
  always_ff @(posedge clk) begin
    if (rst) ver_q <= VERSION;
  end

  // Scratch registers, one flop group per entry
  for (genvar g = 0; g < SCRATCH_N; g++) begin : g_scr
    always_ff @(posedge clk) begin
      if (rst)
        scr_q[g] <= '0;
      else if (wr_en && sel.kind == K_SCR && sel.scr_idx == SCR_W'(g))
        scr_q[g] <= wr_data;
    end
  end

  always_comb begin
    scr_rd = '0;
    for (int i = 0; i < SCRATCH_N; i++)
      if (sel.scr_idx == SCR_W'(i)) scr_rd = scr_q[i];
  end

  always_comb begin
    case (sel.kind)
      K_XER:   rd_val = xer_body_q | (xer_carry_q ? CARRY_MASK : '0);
      K_DSISR: rd_val = dsisr_q;
      K_DAR:   rd_val = dar_q;
      K_DEC:   rd_val = dec_q;
      K_SDR1:  rd_val = sdr1_q;
      K_SRR0:  rd_val = srr0_q;
      K_SRR1:  rd_val = srr1_q;
      K_TBL:   rd_val = time_base[DATA_W-1:0];
      K_TBU:   rd_val = time_base[2*DATA_W-1:DATA_W];
      K_SCR:   rd_val = scr_rd;
      K_VER:   rd_val = ver_q;
      K_IMP0:  rd_val = imp0_q;
      K_IMP1:  rd_val = imp1_q;
      K_PID:   rd_val = pid_q;
      default: rd_val = '0;
    endcase
  end

endmodule

// File: rtl/spr_access_unit.sv
module spr_access_unit
  import spr_pkg::*;
#(
  parameter int                DATA_W    = 32,
  parameter int                CARRY_BIT = 29,
  parameter int                SCRATCH_N = 4,
  parameter logic [DATA_W-1:0] VERSION   = 32'h0001_0000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          instr,
  input  logic                 acc_en,
  input  logic                 acc_write,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [2*DATA_W-1:0]  time_base,
  input  logic [DATA_W-1:0]    xlat_rdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 xlat_sel,
  output logic                 xlat_write,
  output logic [5:0]           xlat_index,
  output logic [DATA_W-1:0]    xlat_wdata,
  output logic                 timer_arm,
  output logic                 xlat_inval
);

  logic [9:0]        num;
  spr_sel_t          sel;
  logic [5:0]        idx;
  logic              is_xlat;
  logic              bank_we;
  logic [DATA_W-1:0] bank_rd;
  logic              unused_insn_bits;

  assign num              = spr_number(instr);
  assign unused_insn_bits = ^{instr[31:21], instr[10:0]};

  spr_num_decode #(.SCRATCH_N(SCRATCH_N)) u_dec (
    .num      (num),
    .sel      (sel),
    .xlat_idx (idx)
  );

  assign is_xlat = (sel.kind == K_XLAT);
  assign bank_we = acc_en & acc_write & ~is_xlat;

  spr_reg_bank #(
    .DATA_W    (DATA_W),
    .CARRY_BIT (CARRY_BIT),
    .SCRATCH_N (SCRATCH_N),
    .VERSION   (VERSION)
  ) u_bank (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (bank_we),
    .sel         (sel),
    .wr_data     (wr_data),
    .time_base   (time_base),
    .rd_val      (bank_rd),
    .arm_pulse   (timer_arm),
    .inval_pulse (xlat_inval)
  );

  assign xlat_sel   = acc_en & is_xlat;
  assign xlat_write = xlat_sel & acc_write;
  assign xlat_index = idx;
  assign xlat_wdata = wr_data;

  always_comb begin
    if (acc_en && !acc_write)
      rd_data = is_xlat ? xlat_rdata : bank_rd;
    else
      rd_data = '0;
  end

endmodule

// File: rtl/spr_access_checker.sv
module spr_access_checker #(
  parameter int                DATA_W  = 32,
  parameter logic [DATA_W-1:0] VERSION = '0
) (
  input logic                 clk,
  input logic                 rst,
  input logic [31:0]          instr,
  input logic                 acc_en,
  input logic                 acc_write,
  input logic [2*DATA_W-1:0]  time_base,
  input logic [DATA_W-1:0]    rd_data,
  input logic                 xlat_sel,
  input logic                 xlat_write,
  input logic [5:0]           xlat_index,
  input logic                 timer_arm,
  input logic                 xlat_inval
);

  logic [9:0] n;
  logic       hi_x, wr_dec, wr_base, rd_acc;

  assign n       = {instr[15:11], instr[20:16]};
  assign hi_x    = (n[9:5] == 5'h10) || (n[9:5] == 5'h11);
  assign wr_dec  = acc_en && acc_write && n == 10'd22;
  assign wr_base = acc_en && acc_write && n == 10'd25;
  assign rd_acc  = acc_en && !acc_write;

  AST_ARM_AFTER_DEC: assert property (@(posedge clk) disable iff (rst)
    wr_dec |=> timer_arm); // R4
  AST_ARM_ONLY_DEC: assert property (@(posedge clk) disable iff (rst)
    timer_arm |-> $past(wr_dec)); // R4
  AST_INVAL_AFTER_BASE: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> xlat_inval); // R5
  AST_INVAL_ONLY_BASE: assert property (@(posedge clk) disable iff (rst)
    xlat_inval |-> $past(wr_base)); // R5
  AST_XLAT_ROUTE: assert property (@(posedge clk) disable iff (rst)
    (acc_en && hi_x) |-> (xlat_sel && xlat_index == n[5:0] && xlat_write == acc_write)); // R2
  AST_XLAT_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(acc_en && hi_x) |-> (!xlat_sel && !xlat_write)); // R2
  AST_VER_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && n == 10'd287) |-> rd_data == VERSION); // R8
  AST_TB_LOW: assert property (@(posedge clk) disable iff (rst)
    (rd_acc && n == 10'd268) |-> rd_data == time_base[DATA_W-1:0]); // R7
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_acc |-> rd_data == '0); // R11

endmodule

bind spr_access_unit spr_access_checker #(
  .DATA_W  (DATA_W),
  .VERSION (VERSION)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instr      (instr),
  .acc_en     (acc_en),
  .acc_write  (acc_write),
  .time_base  (time_base),
  .rd_data    (rd_data),
  .xlat_sel   (xlat_sel),
  .xlat_write (xlat_write),
  .xlat_index (xlat_index),
  .timer_arm  (timer_arm),
  .xlat_inval (xlat_inval)
);

// File: tb/tb_spr_access_unit.sv
module tb_spr_access_unit;

  localparam logic [31:0] VER = 32'h7A5C_0103;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = '0;
  logic        acc_en = 1'b0, acc_write = 1'b0;
  logic [31:0] wr_data = '0;
  logic [63:0] time_base = '0;
  logic [31:0] xlat_rdata = '0;
  logic [31:0] rd_data;
  logic        xlat_sel, xlat_write, timer_arm, xlat_inval;
  logic [5:0]  xlat_index;
  logic [31:0] xlat_wdata;

  int nchk = 0, nbad = 0;
  logic [31:0] mdl [0:1023];
  logic exp_arm = 1'b0, exp_inv = 1'b0;

  spr_access_unit #(.DATA_W(32), .CARRY_BIT(29), .SCRATCH_N(4), .VERSION(VER)) dut (
    .clk(clk), .rst(rst), .instr(instr), .acc_en(acc_en), .acc_write(acc_write),
    .wr_data(wr_data), .time_base(time_base), .xlat_rdata(xlat_rdata),
    .rd_data(rd_data), .xlat_sel(xlat_sel), .xlat_write(xlat_write),
    .xlat_index(xlat_index), .xlat_wdata(xlat_wdata),
    .timer_arm(timer_arm), .xlat_inval(xlat_inval));

  always #10 clk = ~clk;  // 50 MHz

  function automatic bit is_xl(input logic [9:0] n);
    return n[9:5] == 5'h10 || n[9:5] == 5'h11;
  endfunction

  function automatic bit is_rw(input logic [9:0] n);
    return n == 1 || n == 18 || n == 19 || n == 22 || n == 25 || n == 26 ||
           n == 27 || (n >= 272 && n <= 275) || n == 945 || n == 1008 || n == 1009;
  endfunction

  function automatic logic [31:0] exp_read(input logic [9:0] n);
    if (is_xl(n))     return xlat_rdata;
    if (n == 268)     return time_base[31:0];
    if (n == 269)     return time_base[63:32];
    if (n == 287)     return VER;
    if (is_rw(n))     return mdl[n];
    return 32'h0;
  endfunction

  function automatic string tag_of(input logic [9:0] n);
    if (is_xl(n))              return "R2 redirect read";
    if (n == 1)                return "R3 carry merge";
    if (n == 268 || n == 269)  return "R7 time base";
    if (n == 287)              return "R8 version";
    if (is_rw(n))              return "R10 readback";
    return "R6 unimplemented";
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic check_pulses();
    chk("R4 timer arm pulse", {63'd0, timer_arm}, {63'd0, exp_arm});
    chk("R5 invalidate pulse", {63'd0, xlat_inval}, {63'd0, exp_inv});
  endtask

  task automatic do_op(input bit wr, input logic [9:0] n, input logic [31:0] d);
    @(negedge clk);
    check_pulses();
    instr      = {6'd31, 5'($urandom), n[4:0], n[9:5], 11'($urandom)};
    acc_en     = 1'b1;
    acc_write  = wr;
    wr_data    = d;
    time_base  = {$urandom, $urandom};
    xlat_rdata = $urandom;
    #2;
    if (is_xl(n)) begin
      chk("R2 redirect select", {63'd0, xlat_sel}, 64'd1);
      chk("R2 redirect index", {58'd0, xlat_index}, {58'd0, n[5:0]});
      chk("R2 redirect write", {63'd0, xlat_write}, {63'd0, wr});
      if (wr) chk("R2 redirect data", {32'd0, xlat_wdata}, {32'd0, d});
    end else begin
      chk("R2 no redirect", {62'd0, xlat_sel, xlat_write}, 64'd0);
    end
    if (wr) chk("R11 read data during write", {32'd0, rd_data}, 64'd0);
    else    chk(tag_of(n), {32'd0, rd_data}, {32'd0, exp_read(n)});
    exp_arm = wr && n == 10'd22;
    exp_inv = wr && n == 10'd25;
    if (wr && is_rw(n)) mdl[n] = d;
  endtask

  task automatic idle();
    @(negedge clk);
    check_pulses();
    acc_en = 1'b0;
    instr  = $urandom;
    #2;
    chk("R11 idle read data", {32'd0, rd_data}, 64'd0);
    exp_arm = 1'b0;
    exp_inv = 1'b0;
  endtask

  function automatic logic [9:0] pick(input int k);
    case (k)
      0: return 10'd1;    1: return 10'd18;   2: return 10'd19;   3: return 10'd22;
      4: return 10'd25;   5: return 10'd26;   6: return 10'd27;   7: return 10'd268;
      8: return 10'd269;  9: return 10'd272;  10: return 10'd273; 11: return 10'd274;
      12: return 10'd275; 13: return 10'd287; 14: return 10'd945; 15: return 10'd1008;
      16: return 10'd1009; 17: return 10'd276; 18: return 10'd0;  19: return 10'd1023;
      20: return {5'h10, 5'($urandom)};
      21: return {5'h11, 5'($urandom)};
      22: return {5'h0F, 5'($urandom)};
      23: return {5'h12, 5'($urandom)};
      default: return 10'($urandom);
    endcase
  endfunction

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state of every implemented number
    for (int k = 0; k < 17; k++) do_op(1'b0, pick(k), 32'h0);
    chk("R9 reset pulses low", {62'd0, timer_arm, xlat_inval}, 64'd0);

    // R1: halves swapped; number 272 = upper 8, lower 16
    do_op(1'b1, 10'd272, 32'hCAFE_0272);
    do_op(1'b0, 10'd272, 32'h0);
    do_op(1'b0, 10'd16, 32'h0);  // R1: halves not swapped is unimplemented

    // R3: carry split and merge
    do_op(1'b1, 10'd1, 32'hFFFF_FFFF); do_op(1'b0, 10'd1, 0);
    do_op(1'b1, 10'd1, 32'h2000_0000); do_op(1'b0, 10'd1, 0);
    do_op(1'b1, 10'd1, 32'hDFFF_FFFF); do_op(1'b0, 10'd1, 0);

    // R4: decrementer write, back-to-back writes keep the pulse up
    do_op(1'b1, 10'd22, 32'h0000_1000);
    do_op(1'b1, 10'd22, 32'h0000_2000);
    do_op(1'b0, 10'd22, 0);
    idle(); idle();

    // R5: page-table base write
    do_op(1'b1, 10'd25, 32'h00AB_0000);
    idle();
    do_op(1'b0, 10'd25, 0);

    // R6: writes to unimplemented numbers; neighbours unchanged
    do_op(1'b1, 10'd276, 32'h1234_5678);
    do_op(1'b0, 10'd276, 0);
    do_op(1'b0, 10'd275, 0);
    do_op(1'b1, 10'd0, 32'hFFFF_FFFF);
    do_op(1'b0, 10'd1, 0);

    // R7, R8: read-only numbers ignore writes
    do_op(1'b1, 10'd268, 32'hFFFF_FFFF);
    do_op(1'b1, 10'd287, 32'h0BAD_0BAD);
    do_op(1'b0, 10'd287, 0);
    do_op(1'b0, 10'd268, 0);
    do_op(1'b0, 10'd269, 0);

    // R2: redirected write leaves the bank untouched (number 528 low bits alias 16)
    do_op(1'b1, {5'h10, 5'd16}, 32'h5555_AAAA);
    do_op(1'b0, 10'd272, 0);
    do_op(1'b0, {5'h11, 5'd31}, 0);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 7) == 0) idle();
      else do_op(1'($urandom), pick($urandom_range(0, 24)), $urandom);
    end
    idle();
    idle();

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule